// File: doc/BRIEF.md
# Serial Command Demultiplexer

This block sits behind a byte-wide serial receiver and splits the received stream into two kinds of traffic. A frame that opens with a non-zero byte is pass-through traffic. That opening byte is a length N, and the N bytes after it are sent out unchanged on a target byte port. A frame that opens with 0x00 is an escape. The byte after the escape is a local command for the controller. The command can raise a one-cycle strobe (controller-logic reset, target reset, glitch arm), or it can start loading one of three timing parameters from a fixed number of little-endian data bytes.

The parameter registers hold a delay, a pulse width and a repeat count. They feed the downstream timing sequencer directly, and every data byte lands in its register as soon as the byte is accepted. Input is taken only while the downstream port is ready. The input ready output follows the output ready input, so a stalled target also stalls parsing.

Top module: `cmd_demux`

## Requirements
- R1: After reset, out_valid, all three strobes and all parameter registers are zero, and the parser waits for a frame header.
- R2: For a header byte N in 1..255, each of the next N accepted bytes appears on out_data with out_valid high for exactly one cycle. This happens on the cycle after the byte is accepted, and the value is unchanged.
- R3: After the N-th payload byte, the next accepted byte is read as a new header. A 0x00 or 0xFE inside a payload is forwarded and is not interpreted.
- R4: The command sequence 0x00,0xFF pulses logic_rst_o and clears delay_o, width_o and count_o to zero in that same cycle.
- R5: The command sequence 0x00,0xFE pulses tgt_rst_o.
- R6: The command sequence 0x00,0x00 pulses arm_o.
- R7: Each strobe is high for exactly one cycle, on the cycle after the command byte is accepted. At most one strobe is high at a time.
- R8: The sequence 0x00,0x01 followed by 4 bytes loads delay_o little-endian, so the first data byte goes to bits 7:0.
- R9: The sequence 0x00,0x02 followed by 2 bytes loads width_o little-endian. The sequence 0x00,0x03 followed by 2 bytes loads count_o little-endian.
- R10: A command byte from 0x04 to 0xFD raises no strobe, forwards nothing and changes no parameter, and the byte after it is read as a new header.
- R11: in_ready equals out_ready. A byte presented while out_ready is low is not consumed and has no effect.
- R12: Local command frames and parameter data bytes never appear on the output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | Received byte is present |
| in_ready | output | 1 | Block accepts a byte this cycle |
| out_data | output | 8 | Forwarded byte to the target |
| out_valid | output | 1 | Forwarded byte strobe, one cycle |
| out_ready | input | 1 | Target port can take a byte |
| logic_rst_o | output | 1 | Controller-logic reset strobe |
| tgt_rst_o | output | 1 | Target reset strobe |
| arm_o | output | 1 | Glitch arm strobe |
| delay_o | output | 32 | Delay parameter |
| width_o | output | 16 | Pulse width parameter |
| count_o | output | 16 | Repeat count parameter |

## Verification
The parser state is the risk here. A length counter that is off by one, or a missed return to the header state, shows up on the next byte after the frame. That byte is then either forwarded by mistake or taken as a command, so the fault appears at the ports one cycle after that byte is accepted. The bench places escapes and payload bytes that look like commands straight after frames of length 1, 3 and 255 to expose this. A wrong byte index during a parameter load shows up in the parameter register as soon as the last data byte is accepted, as a value with its bytes in the wrong lanes. The bench uses asymmetric patterns for each parameter to catch this.

// File: rtl/cmd_demux.sv
module cmd_demux #(
  parameter int DLY_BYTES = 4,
  parameter int WID_BYTES = 2,
  parameter int CNT_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             in_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  output logic [7:0]             out_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   logic_rst_o,
  output logic                   tgt_rst_o,
  output logic                   arm_o,
  output logic [8*DLY_BYTES-1:0] delay_o,
  output logic [8*WID_BYTES-1:0] width_o,
  output logic [8*CNT_BYTES-1:0] count_o
);
  localparam int MAXB = (DLY_BYTES > WID_BYTES) ?
                        ((DLY_BYTES > CNT_BYTES) ? DLY_BYTES : CNT_BYTES) :
                        ((WID_BYTES > CNT_BYTES) ? WID_BYTES : CNT_BYTES);
  localparam int IW = $clog2(MAXB + 1);
  localparam logic [IW-1:0] ONE    = IW'(1);
  localparam logic [IW-1:0] LST_D  = IW'(DLY_BYTES - 1);
  localparam logic [IW-1:0] LST_W  = IW'(WID_BYTES - 1);
  localparam logic [IW-1:0] LST_C  = IW'(CNT_BYTES - 1);
  localparam logic [7:0] OP_LRST = 8'hFF;
  localparam logic [7:0] OP_TRST = 8'hFE;
  localparam logic [7:0] OP_ARM  = 8'h00;
  localparam logic [7:0] OP_DLY  = 8'h01;
  localparam logic [7:0] OP_WID  = 8'h02;
  localparam logic [7:0] OP_CNT  = 8'h03;

  typedef enum logic [1:0] {HEAD, FWD, ESC, PARM} st_t;
  st_t            st;
  logic [7:0]     rem;
  logic [1:0]     sel;
  logic [IW-1:0]  idx, last;

  wire take = in_valid & out_ready;
  assign in_ready = out_ready;

  always_comb
    case (sel)
      2'd1:    last = LST_D;
      2'd2:    last = LST_W;
      default: last = LST_C;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= HEAD; rem <= '0; sel <= '0; idx <= '0;
      out_data <= '0; out_valid <= 1'b0;
      logic_rst_o <= 1'b0; tgt_rst_o <= 1'b0; arm_o <= 1'b0;
      delay_o <= '0; width_o <= '0; count_o <= '0;
    end else begin
      out_valid   <= 1'b0;
      logic_rst_o <= 1'b0;
      tgt_rst_o   <= 1'b0;
      arm_o       <= 1'b0;
      if (take)
        case (st)
          HEAD:
            if (in_data == 8'h00) st <= ESC;
            else begin rem <= in_data; st <= FWD; end
          FWD: begin
            out_data  <= in_data;
            out_valid <= 1'b1;
            rem       <= rem - 8'd1;
            if (rem == 8'd1) st <= HEAD;
          end
          ESC: begin
            st  <= HEAD;
            idx <= '0;
            case (in_data)
              OP_LRST: begin
                logic_rst_o <= 1'b1;
                delay_o <= '0; width_o <= '0; count_o <= '0;
              end
              OP_TRST: tgt_rst_o <= 1'b1;
              OP_ARM:  arm_o <= 1'b1;
              OP_DLY:  begin sel <= 2'd1; st <= PARM; end
              OP_WID:  begin sel <= 2'd2; st <= PARM; end
              OP_CNT:  begin sel <= 2'd3; st <= PARM; end
              default: ;
            endcase
          end
          PARM: begin
            for (int k = 0; k < DLY_BYTES; k++)
              if (sel == 2'd1 && idx == IW'(k)) delay_o[8*k +: 8] <= in_data;
            for (int k = 0; k < WID_BYTES; k++)
              if (sel == 2'd2 && idx == IW'(k)) width_o[8*k +: 8] <= in_data;
            for (int k = 0; k < CNT_BYTES; k++)
              if (sel == 2'd3 && idx == IW'(k)) count_o[8*k +: 8] <= in_data;
            idx <= idx + ONE;
            if (idx == last) st <= HEAD;
          end
          default: st <= HEAD;
        endcase
    end

  wire any_stb = logic_rst_o | tgt_rst_o | arm_o;

  p_fwd_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && out_ready));

  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({logic_rst_o, tgt_rst_o, arm_o}));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |=> !any_stb);

  p_lrst_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |-> (delay_o == '0 && width_o == '0 && count_o == '0));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> (!out_valid && !any_stb && $stable(delay_o) &&
                    $stable(width_o) && $stable(count_o)));

  p_no_local_fwd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> !out_valid);
endmodule

// File: tb/cmd_demux_tb.sv
module cmd_demux_tb;
  localparam int TCK = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, logic_rst_o, tgt_rst_o, arm_o;
  logic [7:0]  out_data;
  logic [31:0] delay_o;
  logic [15:0] width_o, count_o;

  int compared = 0, mismatched = 0;
  int n_lrst = 0, n_trst = 0, n_arm = 0;
  logic [7:0] expq[$];
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  cmd_demux u_dut (.clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .logic_rst_o(logic_rst_o), .tgt_rst_o(tgt_rst_o), .arm_o(arm_o),
    .delay_o(delay_o), .width_o(width_o), .count_o(count_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    in_data = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic frame(input int n, input int seed);
    send(8'(n));
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'(seed + i * 37);
      expq.push_back(b);
      send(b);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // monitor: scoreboard pop and strobe shape
  logic prev_stb = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (expq.size() == 0) chk("R12 unexpected forwarded byte", {24'h0, out_data}, 32'hxx);
      else chk("R2 forwarded byte", {24'h0, out_data}, {24'h0, expq.pop_front()});
    end
    if (logic_rst_o) n_lrst++;
    if (tgt_rst_o)   n_trst++;
    if (arm_o)       n_arm++;
    if (prev_stb && (logic_rst_o | tgt_rst_o | arm_o))
      chk("R7 strobe longer than one cycle", 1, 0);
    if (int'(logic_rst_o) + int'(tgt_rst_o) + int'(arm_o) > 1)
      chk("R7 strobes not exclusive", 1, 0);
    prev_stb = logic_rst_o | tgt_rst_o | arm_o;
  end

  initial begin
    #(TCK * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 strobes", {logic_rst_o, tgt_rst_o, arm_o}, 0);
    chk("R1 delay", delay_o, 0);
    chk("R1 width", width_o, 0);
    chk("R1 count", count_o, 0);
    chk("R11 in_ready follows out_ready", in_ready, 1);

    // R2/R3: payload with look-alike command bytes, then an escape
    send(8'd3); expq.push_back(8'h00); send(8'h00);
    expq.push_back(8'hFE); send(8'hFE); expq.push_back(8'hFF); send(8'hFF);
    send(8'h00); send(8'hFE);
    settle();
    chk("R3 frame end then escape", expq.size(), 0);
    chk("R5 target reset strobes", n_trst, 1);
    chk("R3 payload not decoded", n_lrst, 0);

    // R6 after a length-1 frame
    frame(1, 8'h5A);
    send(8'h00); send(8'h00);
    settle();
    chk("R6 arm strobes", n_arm, 1);
    chk("R2 length-1 frame drained", expq.size(), 0);

    // R8/R9 parameter loads
    send(8'h00); send(8'h01); send(8'h78); send(8'h56); send(8'h34); send(8'h12);
    chk("R8 delay little-endian", delay_o, 32'h1234_5678);
    send(8'h00); send(8'h02); send(8'hCD); send(8'hAB);
    chk("R9 width little-endian", width_o, 16'hABCD);
    send(8'h00); send(8'h03); send(8'h05); send(8'h80);
    chk("R9 count little-endian", count_o, 16'h8005);
    settle();
    chk("R12 no bytes forwarded by loads", expq.size(), 0);

    // R10 unknown command, next byte is a header
    send(8'h00); send(8'h07);
    send(8'h02); expq.push_back(8'h11); send(8'h11); expq.push_back(8'h22); send(8'h22);
    settle();
    chk("R10 following frame forwarded", expq.size(), 0);
    chk("R10 no strobe", n_lrst + n_trst + n_arm, 2);
    chk("R10 delay unchanged", delay_o, 32'h1234_5678);

    // R11 stall: header presented while not ready is not consumed
    out_ready = 1'b0;
    @(negedge clk);
    chk("R11 in_ready low", in_ready, 0);
    in_data = 8'h02; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    send(8'h00); send(8'hFE);
    settle();
    chk("R11 stalled byte ignored", n_trst, 2);
    chk("R11 nothing forwarded", expq.size(), 0);

    // long frame, back-to-back
    frame(255, 8'h13);
    settle();
    chk("R2 length-255 frame drained", expq.size(), 0);

    // R4 logic reset clears parameters
    send(8'h00); send(8'hFF);
    chk("R4 logic reset strobe", logic_rst_o, 1);
    chk("R4 delay cleared", delay_o, 0);
    chk("R4 width cleared", width_o, 0);
    chk("R4 count cleared", count_o, 0);
    settle();
    chk("R4 strobe count", n_lrst, 1);
    chk("R7 total strobes", n_lrst + n_trst + n_arm, 4);

    finish_run();
  end
endmodule